// File: doc/BRIEF.md
# Register Init Script Sequencer

The sequencer runs a chip bring-up script kept in a record memory. Software or a boot controller loads a first index and a last index (the last one is excluded) and pulses start. The engine then fetches one 64-bit record per step, decodes its type, and turns it into transactions on two master ports. Register reads and writes go out on a request/acknowledge register port. Copies and fills of memory go out as bursts on a second port. The DMA engine behind that second port is seen only as a request that is held until it is acknowledged.

A record splits into a low word and a high word. The low word carries the record type in bits [7:0] and a 24-bit register offset in bits [31:8]. The high word is read according to the type. It can be an immediate value, a 32-bit fill length, or a pair of 16-bit fields: a data-memory word offset in bits [15:0] and a word count in bits [31:16]. Bulk transfers are cut into bursts of at most `MAX_BURST` words. A transfer larger than the staging buffer (`BUF_WORDS`) is refused and raises the error flag. An unsupported type also raises the error flag, and the walk goes on with the next record.

Top module: `cfg_script_engine`

## Requirements
- R1: After start the records from the first index up to, but not including, the last index are handled in ascending order, one at a time. Each record's low word is type in bits [7:0] and register offset in bits [31:8]; the high word sits in record bits [63:32].
- R2: Type 1 issues one register read (write-enable low) at the record's offset; the returned data is not used.
- R3: Type 2 issues one register write of the high word to the record's offset, with the indirect flag low.
- R4: Type 4 writes a string. For i from 0 to count-1 it writes data-memory word (data offset + i) to register offset + 4*i, with the count in high-word bits [31:16] and the data offset in bits [15:0]. A count of zero issues nothing.
- R5: Type 5 issues the same write sequence as type 4 with the indirect flag high on every write.
- R6: Type 6 zero-fills from the offset for the number of words in the whole high word. It uses fill bursts of `MAX_BURST` words, each advancing the destination by `MAX_BURST`*4 bytes, and a last burst carrying the remainder. Burst source is 0 and the fill flag is high.
- R7: Type 8 copies count words (high-word bits [31:16]) from data offset (bits [15:0]) through copy bursts split as in R6. The source word offset advances by each burst's length.
- R8: A fill or copy whose word count exceeds `BUF_WORDS` issues no burst and sets the error flag. A count equal to `BUF_WORDS` is carried out.
- R9: Any other type, including 3 and 7, issues nothing, sets the error flag, and the walk continues with the next record.
- R10: A register or burst request stays high with stable fields until acknowledged, and never more than one request is active at a time.
- R11: Busy is high from the cycle after an accepted start until done. Done is high for exactly one cycle with busy low. A start while busy is ignored. A start with first index not below the last index gives done at once, with no transactions.
- R12: The error flag is sticky during a run and is cleared when a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (accepted when idle) |
| first_idx_i | input | IDX_W | First record index |
| last_idx_i | input | IDX_W | Index one past the last record |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Sticky error flag for the current or last walk |
| rec_addr_o | output | IDX_W | Record memory index |
| rec_word_i | input | 64 | Record at rec_addr_o (same-cycle read) |
| dat_addr_o | output | 16 | Data memory word address |
| dat_word_i | input | 32 | Data word at dat_addr_o (same-cycle read) |
| reg_req_o | output | 1 | Register transaction request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_ind_o | output | 1 | Write goes through the indirect path |
| reg_addr_o | output | 32 | Register byte address |
| reg_wdata_o | output | 32 | Register write data |
| reg_ack_i | input | 1 | Register transaction acknowledge |
| bst_req_o | output | 1 | Burst request |
| bst_fill_o | output | 1 | 1 = zero fill, 0 = copy |
| bst_src_o | output | 16 | Data memory source word offset |
| bst_dst_o | output | 32 | Destination byte address |
| bst_len_o | output | LEN_W | Burst length in words |
| bst_ack_i | input | 1 | Burst accepted and completed |

## Verification
The bench builds the block with `MAX_BURST` = 8 and `BUF_WORDS` = 64, so a 20-word fill splits into 8+8+4 and a 16-word copy into two full bursts. A count of 64 sits on the buffer limit and 65 just over it, all within a short script. A scoreboard queue holds every register and burst transaction the requirements predict. Acknowledges come after varying delays, so held requests and back-to-back records are both covered.

// File: rtl/cse_pkg.sv
package cse_pkg;

  localparam logic [7:0] OPC_READ  = 8'd1;
  localparam logic [7:0] OPC_WRITE = 8'd2;
  localparam logic [7:0] OPC_STR   = 8'd4;
  localparam logic [7:0] OPC_IND   = 8'd5;
  localparam logic [7:0] OPC_FILL  = 8'd6;
  localparam logic [7:0] OPC_BULK  = 8'd8;

  typedef enum logic [2:0] {
    K_RD, K_WR, K_STR, K_IND, K_FILL, K_COPY, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [23:0] off;
    logic [31:0] arg;
  } rec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_SGL, S_STR, S_BST, S_DONE
  } st_e;

endpackage

// File: rtl/cse_decode.sv
module cse_decode
  import cse_pkg::*;
(
  input  logic [63:0] rec_word_i,
  output rec_t        rec_o
);

  logic [7:0] opc;

  assign opc        = rec_word_i[7:0];
  assign rec_o.off  = rec_word_i[31:8];
  assign rec_o.arg  = rec_word_i[63:32];

  always_comb begin
    unique case (opc)
      OPC_READ:  rec_o.kind = K_RD;
      OPC_WRITE: rec_o.kind = K_WR;
      OPC_STR:   rec_o.kind = K_STR;
      OPC_IND:   rec_o.kind = K_IND;
      OPC_FILL:  rec_o.kind = K_FILL;
      OPC_BULK:  rec_o.kind = K_COPY;
      default:   rec_o.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/cse_burst_split.sv
module cse_burst_split #(
  parameter int MAX_BURST = 128,
  parameter int BUF_WORDS = 1024,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic [31:0]      rem_i,
  input  logic [31:0]      req_len_i,
  output logic [LEN_W-1:0] chunk_o,
  output logic             last_o,
  output logic             too_big_o
);

  localparam logic [31:0] MAX_W = 32'(MAX_BURST);
  localparam logic [31:0] BUF_W = 32'(BUF_WORDS);

  assign last_o    = (rem_i <= MAX_W);
  assign chunk_o   = last_o ? rem_i[LEN_W-1:0] : MAX_W[LEN_W-1:0];
  assign too_big_o = (req_len_i > BUF_W);

endmodule

// File: rtl/cfg_script_engine.sv
module cfg_script_engine
  import cse_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MAX_BURST = 128,
  parameter int BUF_WORDS = 1024,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] rec_addr_o,
  input  logic [63:0]      rec_word_i,
  output logic [15:0]      dat_addr_o,
  input  logic [31:0]      dat_word_i,
  output logic             reg_req_o,
  output logic             reg_we_o,
  output logic             reg_ind_o,
  output logic [31:0]      reg_addr_o,
  output logic [31:0]      reg_wdata_o,
  input  logic             reg_ack_i,
  output logic             bst_req_o,
  output logic             bst_fill_o,
  output logic [15:0]      bst_src_o,
  output logic [31:0]      bst_dst_o,
  output logic [LEN_W-1:0] bst_len_o,
  input  logic             bst_ack_i
);

  localparam int PAD_W = 32 - LEN_W;

  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, end_q, end_d;
  logic             err_q, err_d;
  logic [31:0]      addr_q, addr_d, data_q, data_d, rem_q, rem_d;
  logic [15:0]      src_q, src_d;
  logic             we_q, we_d, ind_q, ind_d, fill_q, fill_d;
  logic             run_en, ctx_en;

  rec_t             rec;
  logic [31:0]      req_len;
  logic [LEN_W-1:0] chunk;
  logic [31:0]      chunk32;
  logic             last_chunk, too_big;

  cse_decode u_dec (
    .rec_word_i (rec_word_i),
    .rec_o      (rec)
  );

  assign req_len = (rec.kind == K_FILL) ? rec.arg : {16'h0, rec.arg[31:16]};

  cse_burst_split #(
    .MAX_BURST (MAX_BURST),
    .BUF_WORDS (BUF_WORDS),
    .LEN_W     (LEN_W)
  ) u_split (
    .rem_i     (rem_q),
    .req_len_i (req_len),
    .chunk_o   (chunk),
    .last_o    (last_chunk),
    .too_big_o (too_big)
  );

  assign chunk32 = {{PAD_W{1'b0}}, chunk};

  // next-state logic
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    end_d  = end_q;
    err_d  = err_q;
    addr_d = addr_q;
    data_d = data_q;
    rem_d  = rem_q;
    src_d  = src_q;
    we_d   = we_q;
    ind_d  = ind_q;
    fill_d = fill_q;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          idx_d = first_idx_i;
          end_d = last_idx_i;
          err_d = 1'b0;
          st_d  = S_DISP;
        end
      end
      S_DISP: begin
        if (idx_q >= end_q) begin
          st_d = S_DONE;
        end else begin
          addr_d = {8'h0, rec.off};
          data_d = rec.arg;
          src_d  = rec.arg[15:0];
          rem_d  = {16'h0, rec.arg[31:16]};
          we_d   = 1'b1;
          ind_d  = 1'b0;
          fill_d = 1'b0;
          unique case (rec.kind)
            K_RD: begin
              we_d = 1'b0;
              st_d = S_SGL;
            end
            K_WR: st_d = S_SGL;
            K_STR, K_IND: begin
              ind_d = (rec.kind == K_IND);
              if (rem_d == 32'h0) idx_d = idx_q + 1'b1;
              else                st_d  = S_STR;
            end
            K_FILL, K_COPY: begin
              if (rec.kind == K_FILL) begin
                fill_d = 1'b1;
                rem_d  = rec.arg;
                src_d  = 16'h0;
              end
              if (too_big) begin
                err_d = 1'b1;
                idx_d = idx_q + 1'b1;
              end else if (rem_d == 32'h0) begin
                idx_d = idx_q + 1'b1;
              end else begin
                st_d = S_BST;
              end
            end
            default: begin
              err_d = 1'b1;
              idx_d = idx_q + 1'b1;
            end
          endcase
        end
      end
      S_SGL: begin
        if (reg_ack_i) begin
          idx_d = idx_q + 1'b1;
          st_d  = S_DISP;
        end
      end
      S_STR: begin
        if (reg_ack_i) begin
          addr_d = addr_q + 32'd4;
          src_d  = src_q + 16'd1;
          rem_d  = rem_q - 32'd1;
          if (rem_q == 32'd1) begin
            idx_d = idx_q + 1'b1;
            st_d  = S_DISP;
          end
        end
      end
      S_BST: begin
        if (bst_ack_i) begin
          addr_d = addr_q + (chunk32 << 2);
          src_d  = src_q + chunk32[15:0];
          rem_d  = rem_q - chunk32;
          if (last_chunk) begin
            idx_d = idx_q + 1'b1;
            st_d  = S_DISP;
          end
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign run_en = (st_q != S_IDLE) || start_i;
  assign ctx_en = (st_q == S_DISP) || (st_q == S_STR && reg_ack_i) ||
                  (st_q == S_BST && bst_ack_i);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      end_q  <= '0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rem_q  <= '0;
      src_q  <= '0;
      we_q   <= 1'b0;
      ind_q  <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (run_en) begin
        idx_q <= idx_d;
        end_q <= end_d;
        err_q <= err_d;
      end
      if (ctx_en) begin
        addr_q <= addr_d;
        data_q <= data_d;
        rem_q  <= rem_d;
        src_q  <= src_d;
        we_q   <= we_d;
        ind_q  <= ind_d;
        fill_q <= fill_d;
      end
    end
  end

  assign busy_o      = (st_q == S_DISP) || (st_q == S_SGL) ||
                       (st_q == S_STR)  || (st_q == S_BST);
  assign done_o      = (st_q == S_DONE);
  assign err_o       = err_q;
  assign rec_addr_o  = idx_q;
  assign dat_addr_o  = src_q;
  assign reg_req_o   = (st_q == S_SGL) || (st_q == S_STR);
  assign reg_we_o    = we_q;
  assign reg_ind_o   = ind_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = (st_q == S_STR) ? dat_word_i : data_q;
  assign bst_req_o   = (st_q == S_BST);
  assign bst_fill_o  = fill_q;
  assign bst_src_o   = fill_q ? 16'h0 : src_q;
  assign bst_dst_o   = addr_q;
  assign bst_len_o   = chunk;

endmodule

// File: rtl/cse_chk.sv
module cse_chk #(
  parameter int MAX_BURST = 128,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             reg_req_o,
  input logic             reg_we_o,
  input logic             reg_ind_o,
  input logic [31:0]      reg_addr_o,
  input logic [31:0]      reg_wdata_o,
  input logic             reg_ack_i,
  input logic             bst_req_o,
  input logic [31:0]      bst_dst_o,
  input logic [LEN_W-1:0] bst_len_o,
  input logic             bst_ack_i
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BURST);

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) &&
      $stable(reg_wdata_o) && $stable(reg_we_o) && $stable(reg_ind_o)); // R10

  AST_BST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bst_req_o && !bst_ack_i |=> bst_req_o && $stable(bst_dst_o) &&
      $stable(bst_len_o)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req_o && bst_req_o)); // R10

  AST_BST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bst_req_o |-> (bst_len_o != '0) && (bst_len_o <= MAX_L)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !reg_req_o && !bst_req_o); // R11

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !done_o |=> busy_o); // R11

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !done_o |=> !err_o); // R12

endmodule

bind cfg_script_engine cse_chk #(
  .MAX_BURST (MAX_BURST),
  .LEN_W     (LEN_W)
) u_cse_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .reg_req_o   (reg_req_o),
  .reg_we_o    (reg_we_o),
  .reg_ind_o   (reg_ind_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .reg_ack_i   (reg_ack_i),
  .bst_req_o   (bst_req_o),
  .bst_dst_o   (bst_dst_o),
  .bst_len_o   (bst_len_o),
  .bst_ack_i   (bst_ack_i)
);

// File: tb/test_cfg_script_engine.sv
`timescale 1ns/1ps
module test_cfg_script_engine;

  localparam int IDX_W = 8;
  localparam int MAXB  = 8;
  localparam int BUFW  = 64;
  localparam int LEN_W = $clog2(MAXB + 1);

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [IDX_W-1:0] first_idx_i, last_idx_i;
  logic             busy_o, done_o, err_o;
  logic [IDX_W-1:0] rec_addr_o;
  logic [63:0]      rec_word_i;
  logic [15:0]      dat_addr_o;
  logic [31:0]      dat_word_i;
  logic             reg_req_o, reg_we_o, reg_ind_o;
  logic [31:0]      reg_addr_o, reg_wdata_o;
  logic             reg_ack_i;
  logic             bst_req_o, bst_fill_o;
  logic [15:0]      bst_src_o;
  logic [31:0]      bst_dst_o;
  logic [LEN_W-1:0] bst_len_o;
  logic             bst_ack_i;

  logic [63:0] rec_mem [0:15];
  logic [31:0] dat_mem [0:63];

  int checks = 0;
  int fails  = 0;

  logic [65:0] reg_q [$];
  logic [56:0] bst_q [$];

  cfg_script_engine #(
    .IDX_W (IDX_W), .MAX_BURST (MAXB), .BUF_WORDS (BUFW)
  ) i_cfg_script_engine (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .first_idx_i (first_idx_i), .last_idx_i (last_idx_i),
    .busy_o (busy_o), .done_o (done_o), .err_o (err_o),
    .rec_addr_o (rec_addr_o), .rec_word_i (rec_word_i),
    .dat_addr_o (dat_addr_o), .dat_word_i (dat_word_i),
    .reg_req_o (reg_req_o), .reg_we_o (reg_we_o), .reg_ind_o (reg_ind_o),
    .reg_addr_o (reg_addr_o), .reg_wdata_o (reg_wdata_o), .reg_ack_i (reg_ack_i),
    .bst_req_o (bst_req_o), .bst_fill_o (bst_fill_o), .bst_src_o (bst_src_o),
    .bst_dst_o (bst_dst_o), .bst_len_o (bst_len_o), .bst_ack_i (bst_ack_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rec_word_i = rec_mem[rec_addr_o[3:0]];
  assign dat_word_i = dat_mem[dat_addr_o[5:0]];

  task automatic chk(input bit ok, input string tag, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [23:0] off,
                                     input logic [31:0] arg);
    return {arg, off, op};
  endfunction

  task automatic push_reg(input bit we, input bit ind, input logic [31:0] a,
                          input logic [31:0] d);
    reg_q.push_back({we, ind, a, we ? d : 32'h0});
  endtask

  task automatic push_bst(input bit fill, input logic [15:0] src,
                          input logic [31:0] dst, input int len);
    bst_q.push_back({fill, src, dst, 8'(len)});
  endtask

  // register port monitor and responder
  int rdly = 0;
  int rsel = 0;
  always @(negedge clk) begin
    if (reg_ack_i) begin
      reg_ack_i = 1'b0;
    end else if (reg_req_o) begin
      if (rdly != 0) begin
        rdly--;
      end else begin
        logic [65:0] got, exp;
        got = {reg_we_o, reg_ind_o, reg_addr_o, reg_we_o ? reg_wdata_o : 32'h0};
        if (reg_q.size() == 0) begin
          chk(1'b0, "R1 unexpected register transaction", 96'(got), 96'h0);
        end else begin
          exp = reg_q.pop_front();
          chk(got == exp, "R2/R3/R4/R5 register transaction", 96'(got), 96'(exp));
        end
        reg_ack_i = 1'b1;
        rsel++;
        rdly = rsel % 3;
      end
    end
  end

  // burst port monitor and responder
  int bdly = 0;
  int bsel = 0;
  always @(negedge clk) begin
    if (bst_ack_i) begin
      bst_ack_i = 1'b0;
    end else if (bst_req_o) begin
      if (bdly != 0) begin
        bdly--;
      end else begin
        logic [56:0] got, exp;
        got = {bst_fill_o, bst_src_o, bst_dst_o, 8'(bst_len_o)};
        if (bst_q.size() == 0) begin
          chk(1'b0, "R8 unexpected burst", 96'(got), 96'h0);
        end else begin
          exp = bst_q.pop_front();
          chk(got == exp, "R6/R7 burst", 96'(got), 96'(exp));
        end
        bst_ack_i = 1'b1;
        bsel++;
        bdly = (bsel % 2) * 2;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  task automatic run(input int first, input int last, input bit exp_err,
                     input bit poke, input string tag);
    int n;
    @(negedge clk);
    first_idx_i = IDX_W'(first);
    last_idx_i  = IDX_W'(last);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o || done_o, {tag, " R11 busy after start"}, 96'(busy_o), 96'h1);
    chk(!err_o, {tag, " R12 error cleared at start"}, 96'(err_o), 96'h0);
    n = 0;
    while (!done_o && n < 5000) begin
      if (poke && n == 4) begin
        first_idx_i = 10;
        last_idx_i  = 11;
        start_i     = 1'b1;  // R11: must be ignored while busy
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk(done_o, {tag, " R11 done seen"}, 96'(done_o), 96'h1);
    chk(!busy_o, {tag, " R11 busy low at done"}, 96'(busy_o), 96'h0);
    chk(err_o == exp_err, {tag, " R8/R9/R12 error flag"}, 96'(err_o), 96'(exp_err));
    @(negedge clk);
    chk(!done_o, {tag, " R11 done one cycle"}, 96'(done_o), 96'h0);
    chk(reg_q.size() == 0, {tag, " R1 register items left"}, 96'(reg_q.size()), 96'h0);
    chk(bst_q.size() == 0, {tag, " R1 burst items left"}, 96'(bst_q.size()), 96'h0);
  endtask

  initial begin
    reg_ack_i   = 1'b0;
    bst_ack_i   = 1'b0;
    start_i     = 1'b0;
    first_idx_i = '0;
    last_idx_i  = '0;
    for (int i = 0; i < 64; i++) dat_mem[i] = 32'hC0DE_0000 | 32'(i * 7);
    rec_mem[0]  = mk(8'd2, 24'h000100, 32'hDEAD_BEEF);
    rec_mem[1]  = mk(8'd1, 24'h000204, 32'h0);
    rec_mem[2]  = mk(8'd4, 24'h000300, {16'd3, 16'd2});
    rec_mem[3]  = mk(8'd5, 24'h000400, {16'd2, 16'd10});
    rec_mem[4]  = mk(8'd3, 24'h000500, 32'h1234);
    rec_mem[5]  = mk(8'd6, 24'h001000, 32'd20);
    rec_mem[6]  = mk(8'd8, 24'h002000, {16'd16, 16'd5});
    rec_mem[7]  = mk(8'd6, 24'h004000, 32'd65);
    rec_mem[8]  = mk(8'd8, 24'h003000, {16'd64, 16'd0});
    rec_mem[9]  = mk(8'd7, 24'h006000, {16'd4, 16'd0});
    rec_mem[10] = mk(8'd2, 24'hFFFFF0, 32'h0000_0055);
    rec_mem[11] = mk(8'd4, 24'h007000, {16'd0, 16'd1});
    rec_mem[12] = mk(8'd8, 24'h008000, {16'd65, 16'd0});
    rec_mem[13] = mk(8'd0, 24'h0, 32'h0);
    rec_mem[14] = mk(8'd0, 24'h0, 32'h0);
    rec_mem[15] = mk(8'd0, 24'h0, 32'h0);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o,    "R11 reset busy",  96'(busy_o), 96'h0);
    chk(!done_o,    "R11 reset done",  96'(done_o), 96'h0);
    chk(!err_o,     "R12 reset error", 96'(err_o), 96'h0);
    chk(!reg_req_o, "R10 reset reg request", 96'(reg_req_o), 96'h0);
    chk(!bst_req_o, "R10 reset burst request", 96'(bst_req_o), 96'h0);

    // full script: R1..R9, start poke while busy (R11)
    push_reg(1, 0, 32'h100, 32'hDEAD_BEEF);                 // R3
    push_reg(0, 0, 32'h204, 32'h0);                         // R2
    for (int i = 0; i < 3; i++) push_reg(1, 0, 32'h300 + 32'(4*i), dat_mem[2+i]);  // R4
    for (int i = 0; i < 2; i++) push_reg(1, 1, 32'h400 + 32'(4*i), dat_mem[10+i]); // R5
    push_bst(1, 16'd0, 32'h1000, 8);                        // R6
    push_bst(1, 16'd0, 32'h1020, 8);
    push_bst(1, 16'd0, 32'h1040, 4);
    push_bst(0, 16'd5,  32'h2000, 8);                       // R7
    push_bst(0, 16'd13, 32'h2020, 8);
    for (int k = 0; k < 8; k++) push_bst(0, 16'(8*k), 32'h3000 + 32'(32*k), 8); // R8 limit
    push_reg(1, 0, 32'h00FF_FFF0, 32'h55);                  // R9 continue after bad
    run(0, 11, 1'b1, 1'b1, "script");

    // error cleared by a clean run
    push_reg(1, 0, 32'h100, 32'hDEAD_BEEF);
    push_reg(0, 0, 32'h204, 32'h0);
    run(0, 2, 1'b0, 1'b0, "R12 clean");

    // empty range and reversed range
    run(5, 5, 1'b0, 1'b0, "R11 empty");
    run(9, 3, 1'b0, 1'b0, "R11 reversed");

    // zero-length string: no writes
    run(11, 12, 1'b0, 1'b0, "R4 zero length");

    // oversize copy only
    run(12, 13, 1'b1, 1'b0, "R8 oversize copy");

    // single unknown opcode 0
    run(13, 14, 1'b1, 1'b0, "R9 opcode 0");

    summary();
  end

endmodule